// File: doc/BRIEF.md
# NAND Page Layout Walker

This block steps through the bytes of one physical NAND page, in the order they cross the flash interface, and tags each byte with where it belongs. A byte goes either to the user data buffer or to the logical spare buffer. The tag also gives the byte's index inside that buffer. A companion datapath uses the tag to route the raw byte stream during a raw page read or raw page program. This block moves no data itself.

The page is described by three runtime inputs: the number of user data bytes in a page, the size of an ECC packet, and the number of ECC bytes stored per packet. The physical page starts with a short metadata field. Data packets and their ECC bytes follow in turn. A 6-byte bad-block-marker area sits at the physical offset equal to the data size, so it can land inside the last packet. The logical spare buffer holds these fields in a different order: marker first, then metadata, then the ECC bytes of each packet. A start pulse loads the geometry and presents the first byte's tag. Each advance pulse moves to the next byte.

Top module: `nand_page_walker`

## Requirements
- R1: After reset, and until the first start pulse, tag_sel=0, tag_idx=0, tag_last=0 and walk_done=0. Advance pulses have no effect in this state.
- R2: In the cycle after a start pulse, the tag shows the first metadata byte. The 4 metadata bytes map to spare indices 6, 7, 8 and 9. Encoding: tag_sel=1 means spare buffer, tag_sel=0 means data buffer.
- R3: Each advance taken while walking moves the tag by exactly one byte position, one cycle later. In a cycle with no advance and no start, the tag does not change.
- R4: After the metadata, full packets are emitted (packet-size data bytes, then that packet's ECC bytes) for as long as the page data size minus the physical position exceeds one packet size.
- R5: The 6 marker bytes start at physical offset equal to the page data size and map to spare indices 0 to 5, in order.
- R6: The final packet is split: the data bytes that remain before the marker, then the marker, then the rest of the packet, then its ECC bytes. A split part of length zero is skipped.
- R7: ECC byte k of packet i maps to spare index 10 + i*E + k, where E is the ECC bytes per packet.
- R8: Data bytes take data indices 0, 1, 2, ... with no gap, including across the marker split.
- R9: tag_last is 1 while the tag shows the final ECC byte. The advance taken there sets walk_done one cycle later and clears tag_last. While done, advances are ignored and the tag holds, until the next start.
- R10: A start pulse restarts the walk from the metadata at any time, even in the middle of a walk. Start takes priority over an advance in the same cycle.
- R11: When the geometry is consistent (whole packets fill the data size), one walk hits every spare index from 0 to 10 + steps*E - 1 exactly once.
- R12: The package function for ECC size returns ceil(strength*15/8). For example, strength 1 gives 2, strength 4 gives 8 and strength 8 gives 15.
- R13: With the default configuration-hold option, the geometry is captured at the start pulse. Changes to the geometry inputs during a walk have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new walk; loads the geometry |
| adv | input | 1 | One flash byte consumed; step to the next position |
| page_bytes | input | PAGE_W | User data bytes per page (offset of the marker) |
| pkt_bytes | input | PKT_W | Data bytes per ECC packet |
| ecc_bytes | input | ECC_W | ECC bytes stored per packet |
| tag_sel | output | 1 | 0 = data buffer, 1 = spare buffer |
| tag_idx | output | IDX_W | Index inside the selected buffer |
| tag_last | output | 1 | Current byte is the final byte of the page |
| walk_done | output | 1 | The walk has finished |

## Verification
Every tag output comes from a register. A start or an accepted advance at a clock edge is visible on tag_sel, tag_idx and tag_last from that edge on. walk_done rises on the edge of the advance taken on the final byte. The bench drives start and advance just after a falling edge, and compares all four outputs with its reference one falling edge later, so each result is sampled half a period after it is due. Spare-buffer coverage is added up from the observed tags and checked once per walk.

// File: rtl/nwalk_pkg.sv
package nwalk_pkg;

   typedef enum logic [2:0] {
      SG_META,   // leading metadata field
      SG_BODY,   // data of a packet that lies wholly before the marker
      SG_PAR,    // ECC bytes of such a packet
      SG_HEAD,   // last packet, data before the marker
      SG_MARK,   // bad-block-marker area
      SG_REST,   // last packet, data after the marker
      SG_LPAR    // ECC bytes of the last packet
   } seg_e;

   localparam int META_LEN      = 4;
   localparam int MARK_LEN      = 6;
   localparam int SPARE_META_AT = MARK_LEN;
   localparam int SPARE_ECC_AT  = MARK_LEN + META_LEN;
   localparam int FIELD_DEG     = 15;

   function automatic int unsigned ecc_bytes_for(input int unsigned strength);
      return (strength * FIELD_DEG + 7) / 8;
   endfunction

   function automatic logic seg_is_data(input seg_e s);
      return (s == SG_BODY) || (s == SG_HEAD) || (s == SG_REST);
   endfunction

endpackage

// File: rtl/nwalk_next.sv
module nwalk_next
   import nwalk_pkg::*;
#(
   parameter int PAGE_W = 16,
   parameter int PKT_W  = 12,
   parameter int ECC_W  = 8,
   parameter int POS_W  = PAGE_W + 2,
   parameter int LEN_W  = PAGE_W
) (
   input  seg_e             seg_i,
   input  logic [POS_W-1:0] phys_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic [PKT_W-1:0] pkt_i,
   input  logic [ECC_W-1:0] ecc_i,
   input  logic [LEN_W-1:0] tail_i,
   output seg_e             nseg_o,
   output logic [LEN_W-1:0] nlen_o,
   output logic [LEN_W-1:0] ntail_o,
   output logic             final_o
);
   localparam int XW = POS_W + 1;

   logic [XW-1:0]    room;     // bytes left before the marker after this byte
   logic             room_neg;
   logic             room_gt_pkt;
   logic             room_nz;
   logic [LEN_W-1:0] room_len;

   always_comb begin
      room        = XW'(page_i) - XW'(phys_i) - XW'(1);
      room_neg    = room[XW-1];
      room_gt_pkt = !room_neg && (room > XW'(pkt_i));
      room_nz     = !room_neg && (room != '0);
      room_len    = LEN_W'(room);
   end

   always_comb begin
      nseg_o  = seg_i;
      nlen_o  = LEN_W'(MARK_LEN);
      ntail_o = tail_i;
      final_o = (seg_i == SG_LPAR);
      case (seg_i)
         SG_META, SG_PAR: begin
            if (room_gt_pkt) begin
               nseg_o = SG_BODY;
               nlen_o = LEN_W'(pkt_i);
            end else if (room_nz) begin
               nseg_o  = SG_HEAD;
               nlen_o  = room_len;
               ntail_o = LEN_W'(pkt_i) - room_len;
            end else begin
               nseg_o  = SG_MARK;
               nlen_o  = LEN_W'(MARK_LEN);
               ntail_o = LEN_W'(pkt_i);
            end
         end
         SG_BODY: begin
            nseg_o = SG_PAR;
            nlen_o = LEN_W'(ecc_i);
         end
         SG_HEAD: begin
            nseg_o = SG_MARK;
            nlen_o = LEN_W'(MARK_LEN);
         end
         SG_MARK: begin
            if (tail_i != '0) begin
               nseg_o = SG_REST;
               nlen_o = tail_i;
            end else begin
               nseg_o = SG_LPAR;
               nlen_o = LEN_W'(ecc_i);
            end
         end
         SG_REST: begin
            nseg_o = SG_LPAR;
            nlen_o = LEN_W'(ecc_i);
         end
         default: begin
            nseg_o = seg_i;
            nlen_o = LEN_W'(ecc_i);
         end
      endcase
   end

endmodule

// File: rtl/nwalk_tagmap.sv
module nwalk_tagmap
   import nwalk_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int IDX_W = 17
) (
   input  seg_e             seg_i,
   input  logic [LEN_W-1:0] off_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [IDX_W-1:0] dbase_i,
   input  logic [IDX_W-1:0] ebase_i,
   output logic             sel_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             tail_o
);
   always_comb begin
      sel_o  = 1'b1;
      idx_o  = IDX_W'(off_i);
      tail_o = (seg_i == SG_LPAR) && (off_i == len_i - 1'b1);
      case (seg_i)
         SG_META:                 idx_o = IDX_W'(SPARE_META_AT) + IDX_W'(off_i);
         SG_BODY, SG_HEAD, SG_REST: begin
            sel_o = 1'b0;
            idx_o = dbase_i + IDX_W'(off_i);
         end
         SG_PAR, SG_LPAR:         idx_o = ebase_i + IDX_W'(off_i);
         default:                 idx_o = IDX_W'(off_i);
      endcase
   end
endmodule

// File: rtl/nand_page_walker.sv
module nand_page_walker
   import nwalk_pkg::*;
#(
   parameter int PAGE_W   = 16,
   parameter int PKT_W    = 12,
   parameter int ECC_W    = 8,
   parameter int IDX_W    = PAGE_W + 1,
   parameter bit HOLD_CFG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              adv,
   input  logic [PAGE_W-1:0] page_bytes,
   input  logic [PKT_W-1:0]  pkt_bytes,
   input  logic [ECC_W-1:0]  ecc_bytes,
   output logic              tag_sel,
   output logic [IDX_W-1:0]  tag_idx,
   output logic              tag_last,
   output logic              walk_done
);
   localparam int POS_W = PAGE_W + 2;
   localparam int LEN_W = PAGE_W;

   if (PKT_W > PAGE_W) begin : g_chk_pkt
      $error("nand_page_walker: PKT_W must not exceed PAGE_W");
   end
   if (ECC_W > PAGE_W) begin : g_chk_ecc
      $error("nand_page_walker: ECC_W must not exceed PAGE_W");
   end
   if (IDX_W <= PAGE_W) begin : g_chk_idx
      $error("nand_page_walker: IDX_W must exceed PAGE_W");
   end
   if (PAGE_W < 4) begin : g_chk_page
      $error("nand_page_walker: PAGE_W too small");
   end

   // geometry in use for the walk
   logic [PAGE_W-1:0] cfg_page;
   logic [PKT_W-1:0]  cfg_pkt;
   logic [ECC_W-1:0]  cfg_ecc;

   if (HOLD_CFG) begin : g_hold_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_page <= '0;
            cfg_pkt  <= '0;
            cfg_ecc  <= '0;
         end else if (start) begin
            cfg_page <= page_bytes;
            cfg_pkt  <= pkt_bytes;
            cfg_ecc  <= ecc_bytes;
         end
      end
   end else begin : g_live_cfg
      assign cfg_page = page_bytes;
      assign cfg_pkt  = pkt_bytes;
      assign cfg_ecc  = ecc_bytes;
   end

   // cursor state
   logic             walk_q, done_q;
   seg_e             seg_q;
   logic [LEN_W-1:0] off_q, len_q, tail_q;
   logic [POS_W-1:0] phys_q;
   logic [IDX_W-1:0] dbase_q, ebase_q;

   logic             n_walk, n_done;
   seg_e             n_seg;
   logic [LEN_W-1:0] n_off, n_len, n_tail;
   logic [POS_W-1:0] n_phys;
   logic [IDX_W-1:0] n_dbase, n_ebase;
   logic             upd_tag;

   seg_e             nx_seg;
   logic [LEN_W-1:0] nx_len, nx_tail;
   logic             at_final;

   nwalk_next #(
      .PAGE_W(PAGE_W), .PKT_W(PKT_W), .ECC_W(ECC_W),
      .POS_W(POS_W), .LEN_W(LEN_W)
   ) u_next (
      .seg_i   (seg_q),
      .phys_i  (phys_q),
      .page_i  (cfg_page),
      .pkt_i   (cfg_pkt),
      .ecc_i   (cfg_ecc),
      .tail_i  (tail_q),
      .nseg_o  (nx_seg),
      .nlen_o  (nx_len),
      .ntail_o (nx_tail),
      .final_o (at_final)
   );

   logic seg_end;
   assign seg_end = (off_q == len_q - 1'b1);

   always_comb begin
      n_walk  = walk_q;
      n_done  = done_q;
      n_seg   = seg_q;
      n_off   = off_q;
      n_len   = len_q;
      n_tail  = tail_q;
      n_phys  = phys_q;
      n_dbase = dbase_q;
      n_ebase = ebase_q;
      upd_tag = 1'b0;
      if (start) begin
         n_walk  = 1'b1;
         n_done  = 1'b0;
         n_seg   = SG_META;
         n_off   = '0;
         n_len   = LEN_W'(META_LEN);
         n_tail  = '0;
         n_phys  = '0;
         n_dbase = '0;
         n_ebase = IDX_W'(SPARE_ECC_AT);
         upd_tag = 1'b1;
      end else if (walk_q && adv) begin
         if (!seg_end) begin
            n_off   = off_q + 1'b1;
            n_phys  = phys_q + 1'b1;
            upd_tag = 1'b1;
         end else if (at_final) begin
            n_walk = 1'b0;
            n_done = 1'b1;
         end else begin
            n_seg   = nx_seg;
            n_len   = nx_len;
            n_tail  = nx_tail;
            n_off   = '0;
            n_phys  = phys_q + 1'b1;
            upd_tag = 1'b1;
            if (seg_is_data(seg_q))
               n_dbase = dbase_q + IDX_W'(len_q);
            if (seg_q == SG_PAR)
               n_ebase = ebase_q + IDX_W'(cfg_ecc);
         end
      end
   end

   logic             map_sel, map_last;
   logic [IDX_W-1:0] map_idx;

   nwalk_tagmap #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_map (
      .seg_i   (n_seg),
      .off_i   (n_off),
      .len_i   (n_len),
      .dbase_i (n_dbase),
      .ebase_i (n_ebase),
      .sel_o   (map_sel),
      .idx_o   (map_idx),
      .tail_o  (map_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         walk_q  <= 1'b0;
         done_q  <= 1'b0;
         seg_q   <= SG_META;
         off_q   <= '0;
         len_q   <= '0;
         tail_q  <= '0;
         phys_q  <= '0;
         dbase_q <= '0;
         ebase_q <= '0;
      end else begin
         walk_q  <= n_walk;
         done_q  <= n_done;
         seg_q   <= n_seg;
         off_q   <= n_off;
         len_q   <= n_len;
         tail_q  <= n_tail;
         phys_q  <= n_phys;
         dbase_q <= n_dbase;
         ebase_q <= n_ebase;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_sel  <= 1'b0;
         tag_idx  <= '0;
         tag_last <= 1'b0;
      end else if (upd_tag) begin
         tag_sel  <= map_sel;
         tag_idx  <= map_idx;
         tag_last <= map_last;
      end else if (n_done) begin
         tag_last <= 1'b0;
      end
   end

   assign walk_done = done_q;

endmodule

// File: rtl/nwalk_chk.sv
module nwalk_chk #(
   parameter int IDX_W = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             adv,
   input logic             tag_sel,
   input logic [IDX_W-1:0] tag_idx,
   input logic             tag_last,
   input logic             walk_done
);
   logic seen;
   logic roll;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0;
         roll <= 1'b0;
      end else begin
         if (start) seen <= 1'b1;
         roll <= start ? 1'b1 : (walk_done ? 1'b0 : roll);
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !seen |-> (tag_idx == '0) && !tag_sel && !tag_last && !walk_done);

   a_r2_meta_first: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> tag_sel && (tag_idx == IDX_W'(6)) && !walk_done && !tag_last);

   a_r3_hold_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
      !start && !adv |=> $stable(tag_idx) && $stable(tag_sel) && $stable(walk_done));

   a_r5_mark_order: assert property (@(posedge clk) disable iff (!rst_n)
      roll && !walk_done && tag_sel && (tag_idx < IDX_W'(5)) && adv && !start
      |=> tag_sel && (tag_idx == $past(tag_idx) + 1'b1));

   a_r8_data_step: assert property (@(posedge clk) disable iff (!rst_n)
      roll && !walk_done && !tag_sel && !tag_last && adv && !start
      |=> tag_sel || (tag_idx == $past(tag_idx) + 1'b1));

   a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      tag_last && adv && !start |=> walk_done && !tag_last);

   a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done && !start |=> walk_done && $stable(tag_idx) && $stable(tag_sel));

   a_r9_last_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      walk_done |-> !tag_last);

endmodule

bind nand_page_walker nwalk_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .adv       (adv),
   .tag_sel   (tag_sel),
   .tag_idx   (tag_idx),
   .tag_last  (tag_last),
   .walk_done (walk_done)
);

// File: tb/nand_page_walker_test.sv
module nand_page_walker_test;
   localparam int PAGE_W = 16;
   localparam int PKT_W  = 12;
   localparam int ECC_W  = 8;
   localparam int IDX_W  = 17;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n, start, adv;
   logic [PAGE_W-1:0] page_bytes;
   logic [PKT_W-1:0]  pkt_bytes;
   logic [ECC_W-1:0]  ecc_bytes;
   logic              tag_sel, tag_last, walk_done;
   logic [IDX_W-1:0]  tag_idx;

   nand_page_walker #(.PAGE_W(PAGE_W), .PKT_W(PKT_W), .ECC_W(ECC_W), .IDX_W(IDX_W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
      .page_bytes(page_bytes), .pkt_bytes(pkt_bytes), .ecc_bytes(ecc_bytes),
      .tag_sel(tag_sel), .tag_idx(tag_idx), .tag_last(tag_last), .walk_done(walk_done)
   );

   int errs = 0;
   int checks = 0;
   bit finished = 0;

   // reference model
   bit    mq_sel[$];
   int    mq_idx[$];
   string mq_req[$];
   int    k = 0;
   bit    m_walk = 0, m_done = 0, m_last = 0, m_sel = 0, m_stepped = 0, fresh = 0;
   int    m_idx = 0;
   int    sp_total = 0;
   int    cov[256];
   string ctx = "";

   function automatic void put(bit s, int i, string r);
      mq_sel.push_back(s);
      mq_idx.push_back(i);
      mq_req.push_back(r);
   endfunction

   function automatic void build(int pg, int pk, int e);
      int pos = 0, rem, npk = 0, di = 0;
      mq_sel.delete(); mq_idx.delete(); mq_req.delete();
      for (int j = 0; j < 4; j++) put(1, 6 + j, "R2");
      pos = 4;
      rem = pg - pos;
      while (rem > pk) begin
         for (int j = 0; j < pk; j++) begin put(0, di, "R4"); di++; end
         pos += pk;
         for (int j = 0; j < e; j++) put(1, 10 + npk * e + j, "R7");
         pos += e;
         npk++;
         rem = pg - pos;
      end
      for (int j = 0; j < rem; j++) begin put(0, di, "R6"); di++; end
      for (int j = 0; j < 6; j++) put(1, j, "R5");
      for (int j = 0; j < pk - rem; j++) begin put(0, di, "R8"); di++; end
      for (int j = 0; j < e; j++) put(1, 10 + npk * e + j, "R6");
      npk++;
      sp_total = 10 + npk * e;
   endfunction

   task automatic compare();
      string r;
      checks++;
      if (ctx != "") r = ctx;
      else if (m_done || m_last) r = "R9";
      else if (!m_walk) r = "R1";
      else if (!m_stepped) r = "R3";
      else r = mq_req[k];
      if (tag_sel !== m_sel || tag_idx !== IDX_W'(m_idx) || tag_last !== m_last ||
          walk_done !== m_done) begin
         errs++;
         $display("FAIL %s: got sel=%0d idx=%0d last=%0d done=%0d, expected sel=%0d idx=%0d last=%0d done=%0d",
                  r, tag_sel, tag_idx, tag_last, walk_done, m_sel, m_idx, m_last, m_done);
      end
      if (fresh && tag_sel === 1'b1 && tag_idx < 256) cov[tag_idx]++;
      fresh = 0;
   endtask

   task automatic update(bit s, bit a);
      m_stepped = s || a;
      if (s) begin
         build(int'(page_bytes), int'(pkt_bytes), int'(ecc_bytes));
         for (int j = 0; j < 256; j++) cov[j] = 0;
         k = 0; m_walk = 1; m_done = 0;
         m_sel = mq_sel[0]; m_idx = mq_idx[0];
         m_last = (mq_sel.size() == 1);
         fresh = 1;
      end else if (m_walk && a) begin
         if (k == mq_sel.size() - 1) begin
            m_walk = 0; m_done = 1; m_last = 0;
         end else begin
            k++;
            m_sel = mq_sel[k]; m_idx = mq_idx[k];
            m_last = (k == mq_sel.size() - 1);
            fresh = 1;
         end
      end
   endtask

   task automatic tick(bit s, bit a);
      @(negedge clk);
      compare();
      start = s;
      adv   = a;
      @(posedge clk);
      #1;
      update(s, a);
   endtask

   function automatic bit pattern(int mode, int n);
      if (mode == 0) return 1'b1;
      if (mode == 1) return n[0];
      return 1'($urandom_range(0, 1));
   endfunction

   task automatic set_geo(int pg, int pk, int strength);
      page_bytes = PAGE_W'(pg);
      pkt_bytes  = PKT_W'(pk);
      ecc_bytes  = ECC_W'((strength * 15 + 7) / 8);
   endtask

   task automatic finish_walk(int mode);
      int n = 0;
      while (!m_done && n < 5000) begin
         tick(0, pattern(mode, n));
         n++;
      end
      tick(0, 1);   // ignored once done (R9)
      tick(0, 1);
      tick(0, 0);
   endtask

   task automatic cover_check(string r);
      int bad = 0;
      checks++;
      for (int j = 0; j < 256; j++) begin
         if (j < sp_total && cov[j] != 1) bad++;
         if (j >= sp_total && cov[j] != 0) bad++;
      end
      if (bad != 0) begin
         errs++;
         $display("FAIL %s: spare coverage wrong at %0d indices, expected 0 (span %0d)", r, bad, sp_total);
      end
   endtask

   task automatic check_ecc_fn(int s, int expv);
      int got;
      checks++;
      got = int'(nwalk_pkg::ecc_bytes_for(s));
      if (got != expv) begin
         errs++;
         $display("FAIL R12: strength %0d got %0d expected %0d", s, got, expv);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; adv = 1'b0;
      set_geo(0, 0, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, advances ignored before any start
      ctx = "R1";
      repeat (4) tick(0, 1);
      ctx = "";

      // R12: ECC size helper
      check_ecc_fn(1, 2);
      check_ecc_fn(2, 4);
      check_ecc_fn(3, 6);
      check_ecc_fn(4, 8);
      check_ecc_fn(8, 15);
      check_ecc_fn(16, 30);

      // R4 R5 R7: marker falls exactly on a packet boundary
      set_geo(64, 16, 2);
      tick(1, 0);
      finish_walk(0);
      cover_check("R11");

      // R6 R8: marker splits the last packet, irregular advances (R3)
      set_geo(60, 20, 1);
      tick(1, 0);
      finish_walk(2);
      cover_check("R11");

      // single packet split, alternating advances
      set_geo(32, 32, 4);
      tick(1, 0);
      finish_walk(1);
      cover_check("R11");

      // R13: geometry changes mid-walk do not alter the walk
      set_geo(64, 16, 2);
      tick(1, 0);
      ctx = "R13";
      repeat (10) tick(0, 1);
      set_geo(32, 32, 4);
      finish_walk(0);
      ctx = "";
      cover_check("R13");

      // R10: restart mid-walk with start and advance together
      set_geo(60, 20, 1);
      tick(1, 0);
      repeat (15) tick(0, 1);
      set_geo(32, 32, 4);
      ctx = "R10";
      tick(1, 1);
      tick(0, 1);
      ctx = "";
      finish_walk(0);
      cover_check("R10");

      summary();
   end
endmodule